// File: doc/BRIEF.md
# Deferred Register Writeback Merger

This block sits beside a register file. It holds the results of a secondary operation that runs in parallel with a main operation and writes them back only after the main operation has finished. Both operations read the same register state. Where both write the same register, the final value is the bitwise OR of the two results.

The sequence of use is fixed. The secondary operation first fills up to four log slots, each with a register index and a value. After the main operation has read its operands, a clear command writes zero to every logged register. The main operation then writes its own results. Last, an apply command ORs each logged value into the register it names.

A clear can spare all three words of one accumulator. Every slot command scans the log from slot 0, one register write per cycle, and stops at the first empty slot. The block drives one write port and one read address into the register file and reads back a combinational read value.

Top module: `wb_merge_log`

## Requirements
- R1: After reset, `busy` and `rf_we` are low and every log slot is empty.
- R2: While idle, a pulse on `log_we` stores `log_idx` and `log_val` in slot `log_slot` (0 to 3) and marks that slot filled.
- R3: A clear command (`clr_req`) starts a scan in the next cycle. The scan spends one cycle on each leading filled slot and writes zero to the register that slot names. The clear leaves the slots filled.
- R4: When `clr_keep` is high with the clear command, `clr_acc` = a selects an accumulator. The scan issues no write for an entry whose index is 24+a (low word), 26+a (middle word) or 28+a (high word).
- R5: An apply command (`apply_req`) starts a scan in the next cycle. The scan takes slots in ascending order, one per cycle, and writes `rf_rdata | value` to the register the slot names. A register therefore ends as its current content ORed with every value logged for it.
- R6: Each slot becomes empty in the cycle after it is applied. A second apply with no new entries does nothing.
- R7: A scan stops at the first empty slot. Filled slots after that gap keep their contents for a later scan.
- R8: `busy` is high from the cycle after an accepted command until the cycle that handles the last leading filled slot. For N leading filled slots it is high for exactly N cycles.
- R9: While `busy` is high, `log_we`, `clr_req` and `apply_req` are ignored.
- R10: If `clr_req` and `apply_req` arrive in the same idle cycle, the clear is performed and the apply is dropped.
- R11: A command issued while slot 0 is empty leaves `busy` low and makes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| log_we | input | 1 | Store one log entry |
| log_slot | input | 2 | Slot number for the entry |
| log_idx | input | 5 | Destination register index |
| log_val | input | 16 | Value to merge |
| clr_req | input | 1 | Clear logged destinations |
| clr_keep | input | 1 | Spare one accumulator during the clear |
| clr_acc | input | 1 | Accumulator to spare |
| apply_req | input | 1 | Merge the log into the register file |
| rf_rdata | input | 16 | Combinational read data for `rf_raddr` |
| rf_raddr | output | 5 | Read address (index in the current slot) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write address |
| rf_wdata | output | 16 | Register write data |
| busy | output | 1 | Scan in progress |

## Verification
A command is sampled at one rising edge. From the next cycle, `busy` and the write for slot k are visible on the ports k cycles later. The register file takes each write at the following edge. The bench drives and samples on falling edges. At each sample point it counts the cycles in which `busy` and `rf_we` are high, and it compares the register model only after `busy` has fallen. The sweep covers every log depth, both spare settings and both accumulators, with indices biased toward the accumulator words and toward repeats. From these it computes the expected clear-then-OR contents independently.

// File: rtl/wb_merge_log.sv
module wb_merge_log #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int SLOTS       = 4,
  parameter int ACC_LO_BASE = 24,
  parameter int ACC_MI_BASE = 26,
  parameter int ACC_HI_BASE = 28
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     log_we,
  input  logic [$clog2(SLOTS)-1:0] log_slot,
  input  logic [ADDR_W-1:0]        log_idx,
  input  logic [DATA_W-1:0]        log_val,
  input  logic                     clr_req,
  input  logic                     clr_keep,
  input  logic                     clr_acc,
  input  logic                     apply_req,
  input  logic [DATA_W-1:0]        rf_rdata,
  output logic [ADDR_W-1:0]        rf_raddr,
  output logic                     rf_we,
  output logic [ADDR_W-1:0]        rf_waddr,
  output logic [DATA_W-1:0]        rf_wdata,
  output logic                     busy
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  typedef enum logic [1:0] {IDLE, CLEAR, APPLY} mode_t;

  mode_t              mode;
  logic [SLOT_W-1:0]  ptr;
  logic               keep_q;
  logic               acc_q;
  logic [SLOTS-1:0]   vld;
  logic [ADDR_W-1:0]  idx [SLOTS];
  logic [DATA_W-1:0]  val [SLOTS];

  function automatic logic hit_acc(input logic [ADDR_W-1:0] a, input logic sel);
    logic [ADDR_W-1:0] o;
    o = ADDR_W'(sel);
    return (a == ADDR_W'(ACC_LO_BASE) + o) ||
           (a == ADDR_W'(ACC_MI_BASE) + o) ||
           (a == ADDR_W'(ACC_HI_BASE) + o);
  endfunction

  logic [SLOT_W-1:0] ptr_inc;
  logic              nxt_vld;
  logic              skip;

  assign ptr_inc = ptr + 1'b1;
  assign nxt_vld = (ptr != LAST) && vld[ptr_inc];
  assign skip    = keep_q && hit_acc(idx[ptr], acc_q);

  assign busy     = (mode != IDLE);
  assign rf_raddr = idx[ptr];
  assign rf_waddr = idx[ptr];
  assign rf_we    = (mode == APPLY) || ((mode == CLEAR) && !skip);
  assign rf_wdata = (mode == APPLY) ? (rf_rdata | val[ptr]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        idx[s] <= '0;
        val[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (mode == IDLE && log_we && log_slot == SLOT_W'(s)) begin
          vld[s] <= 1'b1;
          idx[s] <= log_idx;
          val[s] <= log_val;
        end else if (mode == APPLY && ptr == SLOT_W'(s)) begin
          vld[s] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= IDLE;
      ptr    <= '0;
      keep_q <= 1'b0;
      acc_q  <= 1'b0;
    end else if (mode == IDLE) begin
      if (vld[0] && (clr_req || apply_req)) begin
        mode   <= clr_req ? CLEAR : APPLY;
        ptr    <= '0;
        keep_q <= clr_keep;
        acc_q  <= clr_acc;
      end
    end else if (nxt_vld) begin
      ptr <= ptr_inc;
    end else begin
      mode <= IDLE;
      ptr  <= '0;
    end
  end
endmodule

// File: rtl/wb_merge_log_chk.sv
module wb_merge_log_chk #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int SLOTS       = 4,
  parameter int ACC_LO_BASE = 24,
  parameter int ACC_MI_BASE = 26,
  parameter int ACC_HI_BASE = 28
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     log_we,
  input logic                     clr_req,
  input logic                     apply_req,
  input logic                     rf_we,
  input logic [ADDR_W-1:0]        rf_waddr,
  input logic [DATA_W-1:0]        rf_wdata,
  input logic [DATA_W-1:0]        rf_rdata,
  input logic [SLOTS-1:0]         vld,
  input logic [$clog2(SLOTS)-1:0] ptr,
  input logic [DATA_W-1:0]        cur_val,
  input logic                     in_apply,
  input logic                     in_clear,
  input logic                     keep_q,
  input logic                     acc_q
);
  logic [ADDR_W-1:0] off;
  logic              spared;
  assign off    = ADDR_W'(acc_q);
  assign spared = (rf_waddr == ADDR_W'(ACC_LO_BASE) + off) ||
                  (rf_waddr == ADDR_W'(ACC_MI_BASE) + off) ||
                  (rf_waddr == ADDR_W'(ACC_HI_BASE) + off);

  // R8
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);

  // R8
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && vld[0] && (clr_req || apply_req)) |=> busy);

  // R5
  apply_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_apply |-> (((rf_wdata & cur_val) == cur_val) && ((rf_wdata & rf_rdata) == rf_rdata)));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_clear && rf_we) |-> (rf_wdata == '0));

  // R4
  keep_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_clear && keep_q && rf_we) |-> !spared);

  // R6
  retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_apply |=> !vld[$past(ptr)]);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !log_we) |=> $stable(vld));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_apply) |=> $stable(vld));
endmodule

bind wb_merge_log wb_merge_log_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS),
  .ACC_LO_BASE(ACC_LO_BASE), .ACC_MI_BASE(ACC_MI_BASE), .ACC_HI_BASE(ACC_HI_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .log_we(log_we),
  .clr_req(clr_req), .apply_req(apply_req),
  .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
  .vld(vld), .ptr(ptr), .cur_val(val[ptr]),
  .in_apply(mode == APPLY), .in_clear(mode == CLEAR),
  .keep_q(keep_q), .acc_q(acc_q)
);

// File: tb/wb_merge_log_bench.sv
module wb_merge_log_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        log_we = 1'b0;
  logic [1:0]  log_slot = '0;
  logic [4:0]  log_idx = '0;
  logic [15:0] log_val = '0;
  logic        clr_req = 1'b0, clr_keep = 1'b0, clr_acc = 1'b0, apply_req = 1'b0;
  logic [15:0] rf_rdata;
  logic [4:0]  rf_raddr, rf_waddr;
  logic        rf_we, busy;
  logic [15:0] rf_wdata;

  logic        m_we = 1'b0;
  logic [4:0]  m_addr = '0;
  logic [15:0] m_data = '0;
  logic [15:0] rf [32];

  int total = 0, bad = 0;
  int cyc_busy, cyc_we;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_NS/2) clk = ~clk;

  wb_merge_log u_wb_merge_log (
    .clk(clk), .rst_n(rst_n), .log_we(log_we), .log_slot(log_slot),
    .log_idx(log_idx), .log_val(log_val), .clr_req(clr_req), .clr_keep(clr_keep),
    .clr_acc(clr_acc), .apply_req(apply_req), .rf_rdata(rf_rdata),
    .rf_raddr(rf_raddr), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .busy(busy)
  );

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (m_we)  rf[m_addr]   <= m_data;
  end

  function automatic logic [15:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:15];
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_reg(input int a, input logic [15:0] d);
    m_we = 1'b1; m_addr = 5'(a); m_data = d;
    @(negedge clk);
    m_we = 1'b0;
  endtask

  task automatic put(input int s, input int a, input logic [15:0] d);
    log_we = 1'b1; log_slot = 2'(s); log_idx = 5'(a); log_val = d;
    @(negedge clk);
    log_we = 1'b0;
  endtask

  // issue command, then count busy cycles and write cycles
  task automatic cmd(input logic c, input logic a, input logic k, input logic s);
    clr_req = c; apply_req = a; clr_keep = k; clr_acc = s;
    @(negedge clk);
    clr_req = 1'b0; apply_req = 1'b0;
    cyc_busy = 0; cyc_we = 0;
    while (busy && cyc_busy < 20) begin
      cyc_busy++;
      if (rf_we) cyc_we++;
      @(negedge clk);
    end
  endtask

  function automatic logic is_acc(input int a, input int s);
    return (a == 24 + s) || (a == 26 + s) || (a == 28 + s);
  endfunction

  task automatic trial(input int n, input logic k, input logic s);
    logic [15:0] orig [32];
    logic [15:0] expv [32];
    logic [15:0] ors  [32];
    logic        clr  [32];
    logic        lg   [32];
    int          ei [4];
    logic [15:0] ev [4];
    int nclr;
    for (int r = 0; r < 32; r++) begin
      orig[r] = rnd(); ors[r] = '0; clr[r] = 1'b0; lg[r] = 1'b0;
      set_reg(r, orig[r]);
    end
    nclr = 0;
    for (int i = 0; i < n; i++) begin
      logic [15:0] t;
      t = rnd();
      ei[i] = t[0] ? 24 + int'(t[7:4]) % 6 : int'(t[12:8]) % 24;
      ev[i] = rnd();
      put(i, ei[i], ev[i]);
      lg[ei[i]] = 1'b1;
      ors[ei[i]] = ors[ei[i]] | ev[i];
      if (!(k && is_acc(ei[i], s))) begin clr[ei[i]] = 1'b1; nclr++; end
    end
    cmd(1'b1, 1'b0, k, s);
    chk(cyc_busy == n, "R8 clear busy cycles", cyc_busy, n);
    chk(cyc_we == nclr, k ? "R4 clear write count" : "R3 clear write count", cyc_we, nclr);
    for (int r = 0; r < 32; r++) begin
      expv[r] = clr[r] ? 16'h0 : orig[r];
      if (lg[r]) chk(rf[r] == expv[r], (k && is_acc(r, s)) ? "R4 spared after clear" : "R3 zero after clear", rf[r], expv[r]);
    end
    for (int r = 0; r < 32; r++) begin
      logic [15:0] t;
      t = rnd();
      if (t[1:0] == 2'b00) begin
        expv[r] = rnd();
        set_reg(r, expv[r]);
      end
      expv[r] = expv[r] | ors[r];
    end
    cmd(1'b0, 1'b1, 1'b0, 1'b0);
    chk(cyc_busy == n, n == 0 ? "R11 apply busy cycles" : "R8 apply busy cycles", cyc_busy, n);
    chk(cyc_we == n, "R5 apply write count", cyc_we, n);
    for (int r = 0; r < 32; r++)
      chk(rf[r] == expv[r], "R5 merged register", rf[r], expv[r]);
    cmd(1'b1, 1'b1, 1'b0, 1'b0);
    chk(cyc_busy == 0 && cyc_we == 0, "R6 log empty after apply", cyc_busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R8 watchdog actual=hung expected=idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) rf[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(rf_we == 1'b0, "R1 write after reset", rf_we, 0);
    cmd(1'b0, 1'b1, 1'b0, 1'b0);
    chk(cyc_busy == 0, "R1 R11 empty log apply", cyc_busy, 0);

    // R7 gap stops the scan, later slot survives
    for (int r = 1; r <= 7; r++) set_reg(r, 16'h0100);
    put(0, 1, 16'h0001); put(1, 2, 16'h0002); put(3, 3, 16'h0004);
    cmd(1'b0, 1'b1, 1'b0, 1'b0);
    chk(cyc_busy == 2, "R7 scan stops at gap", cyc_busy, 2);
    chk(rf[1] == 16'h0101 && rf[2] == 16'h0102, "R2 R5 stored entries merged", rf[2], 16'h0102);
    chk(rf[3] == 16'h0100, "R7 slot past gap untouched", rf[3], 16'h0100);
    put(0, 5, 16'h0008); put(1, 6, 16'h0010); put(2, 7, 16'h0020);
    cmd(1'b0, 1'b1, 1'b0, 1'b0);
    chk(cyc_busy == 4, "R7 kept slot joins later scan", cyc_busy, 4);
    chk(rf[3] == 16'h0104, "R7 kept slot value", rf[3], 16'h0104);
    chk(rf[7] == 16'h0120, "R5 slot 2 merged", rf[7], 16'h0120);

    // R9 inputs ignored while busy
    set_reg(11, 16'h0000);
    put(0, 8, 16'h1); put(1, 9, 16'h1); put(2, 10, 16'h1);
    apply_req = 1'b1;
    @(negedge clk);
    apply_req = 1'b0;
    log_we = 1'b1; log_slot = 2'd0; log_idx = 5'd11; log_val = 16'hFFFF; clr_req = 1'b1;
    @(negedge clk);
    log_we = 1'b0; clr_req = 1'b0;
    while (busy) @(negedge clk);
    cmd(1'b0, 1'b1, 1'b0, 1'b0);
    chk(cyc_busy == 0, "R9 log write ignored while busy", cyc_busy, 0);
    chk(rf[11] == 16'h0000, "R9 register untouched", rf[11], 0);

    // R10 clear wins over apply
    set_reg(12, 16'h0F00);
    put(0, 12, 16'h00F0);
    cmd(1'b1, 1'b1, 1'b0, 1'b0);
    chk(rf[12] == 16'h0000, "R10 clear taken", rf[12], 0);
    cmd(1'b0, 1'b1, 1'b0, 1'b0);
    chk(rf[12] == 16'h00F0, "R10 entry kept for apply", rf[12], 16'h00F0);

    // sweep: depth x spare mode x accumulator
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < 2; s++)
        for (int n = 0; n <= 4; n++)
          for (int rep = 0; rep < 4; rep++)
            trial(n, k[0], s[0]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule